// File: doc/BRIEF.md
# Timer Channel Pin Function Controller

This block is one channel of a general-purpose timer together with the logic that owns its pin. Depending on a global enable, a channel-type select, a two-bit capture edge field and a two-bit compare action field, the pin acts as one of four things: a plain digital input, a plain digital output driven from a port data bit, an input-capture input that latches a free-running counter on a chosen edge, or an output-compare output whose level is set by a match between the counter and a compare register.

A compare action overrides the direction bit and drives the pin, but the direction bit is left as it was. Reads and GPIO behaviour come back as soon as the action field is zero. Capture keeps watching the pin even while the port data bit drives it, so software can raise capture events by writing data. A cross-channel link can push a level into the compare latch of a compare channel. That link has no effect on a capture channel.

All outputs are registered. The pin input passes through a synchronizer before it is used for edge detection or for reads.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `pin_oe`, `pin_out`, `cap_val`, `chan_flag` and `pin_rd` are all 0 after that edge.
- R2: With `tmr_en` = 0, at each clock `pin_oe` takes `dir_bit` and `pin_out` takes `port_data`. No capture or compare event sets `chan_flag`.
- R3: With `tmr_en` = 1, `cmp_sel` = 0 and `edge_sel` = 00, no capture occurs and `cap_val` and `chan_flag` hold. The pin follows `dir_bit` and `port_data` as in R2.
- R4: On a capture channel, `edge_sel` is decoded as 01 = rising, 10 = falling, 11 = either. The source is sampled by a SYNC_STAGES-flop synchronizer. A source change first sampled at edge k is detected by its previous-level flop and captured at edge k+SYNC_STAGES. That edge loads the `cnt_val` present at it into `cap_val` and sets `chan_flag`.
- R5: The capture source is `port_data` when `dir_bit` = 1 and `pin_in` when `dir_bit` = 0.
- R6: On a capture channel, `xlink_mask`, `xlink_evt` and `xlink_lvl` have no effect on any output.
- R7: With `cmp_sel` = 1 and `act_sel` = 00, a clock where `cnt_val` equals `cmp_val` sets `chan_flag`. The pin stays plain I/O as in R2.
- R8: With `tmr_en` = 1, `cmp_sel` = 1 and a nonzero `act_sel`, `pin_oe` is 1 one clock later whatever `dir_bit` holds, and `pin_out` takes the compare latch.
- R9: `act_sel` is decoded as 01 = toggle, 10 = clear, 11 = set. The latch updates at the clock edge that sees the match, and `pin_out` shows it one clock after that.
- R10: At each clock `pin_rd` takes `port_data` when `dir_bit` = 1. Otherwise it takes `pin_in` as seen SYNC_STAGES clocks earlier.
- R11: `chan_flag` stays set until a clock with `flag_clr` = 1 and no set event. If a set and a clear fall on the same clock, the set wins.
- R12: While `tmr_en` = 0 the compare latch is cleared, so a re-enabled compare channel starts driving 0.
- R13: On a compare channel with a nonzero `act_sel` and `xlink_mask` = 1, a clock with `xlink_evt` = 1 loads `xlink_lvl` into the latch. This takes priority over the channel's own match action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Global timer enable |
| dir_bit | input | 1 | Data direction, 1 = output |
| port_data | input | 1 | Port data bit for GPIO output |
| cmp_sel | input | 1 | 0 = capture channel, 1 = compare channel |
| edge_sel | input | 2 | Capture edge select |
| act_sel | input | 2 | Compare action select |
| xlink_mask | input | 1 | Enables the cross-channel link on this channel |
| xlink_evt | input | 1 | Cross-channel compare event |
| xlink_lvl | input | 1 | Level pushed by the cross-channel link |
| cnt_val | input | CNT_W | Free-running counter |
| cmp_val | input | CNT_W | Compare register |
| pin_in | input | 1 | External pin level |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| pin_oe | output | 1 | Pin output enable |
| pin_out | output | 1 | Pin output value |
| cap_val | output | CNT_W | Captured counter value |
| chan_flag | output | 1 | Channel event flag |
| pin_rd | output | 1 | Readable pin state |

## Verification
The assertions assume that all control inputs are stable across a clock edge and only change between edges. They also assume that `pin_in` may be asynchronous, because it is only ever used after the synchronizer. The stimulus changes every input on the falling edge. It moves the counter by one each clock and sets the compare register a few counts ahead, so every match lands well inside a test phase. Control fields are switched only while no capture edge is still in flight through the synchronizer, except where a phase is meant to test a change.

// File: rtl/tmr_pin_pkg.sv
package tmr_pin_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;
endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tpc_edge_cap.sv
module tpc_edge_cap
  import tmr_pin_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  edge_sel_e        edge_sel,
  input  logic             lvl,
  input  logic [CNT_W-1:0] cnt,
  output logic             cap_evt,
  output logic [CNT_W-1:0] cap_q
);
  logic prev_q;
  logic rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign cap_evt = arm & hit;

  always_ff @(posedge clk) begin
    if (rst)          cap_q <= '0;
    else if (cap_evt) cap_q <= cnt;
  end

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> $stable(cap_q));

  // R3
  off_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == EDGE_OFF) |-> !cap_evt);
endmodule

// File: rtl/tpc_oc_latch.sv
module tpc_oc_latch
  import tmr_pin_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  logic    drive,
  input  oc_act_e mode,
  input  logic    hit,
  input  logic    xmask,
  input  logic    xevt,
  input  logic    xlvl,
  output logic    oc_q
);
  logic link_take;

  assign link_take = drive & xmask & xevt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      oc_q <= 1'b0;
    end else if (link_take) begin
      oc_q <= xlvl;
    end else if (hit) begin
      unique case (mode)
        ACT_TOGGLE: oc_q <= ~oc_q;
        ACT_CLEAR:  oc_q <= 1'b0;
        ACT_SET:    oc_q <= 1'b1;
        default:    oc_q <= oc_q;
      endcase
    end
  end

  // R12
  dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !oc_q);

  // R9
  set_act_chk: assert property (@(posedge clk) disable iff (rst)
    (en && hit && mode == ACT_SET && !link_take) |=> oc_q);

  // R9
  toggle_act_chk: assert property (@(posedge clk) disable iff (rst)
    (en && hit && mode == ACT_TOGGLE && !link_take) |=> (oc_q != $past(oc_q)));

  // R13
  link_load_chk: assert property (@(posedge clk) disable iff (rst)
    (en && link_take) |=> (oc_q == $past(xlvl)));
endmodule

// File: rtl/tpc_flag.sv
module tpc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);

  // R11
  clr_works_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set) |=> $stable(flag));
endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
  import tmr_pin_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic             dir_bit,
  input  logic             port_data,
  input  logic             cmp_sel,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       act_sel,
  input  logic             xlink_mask,
  input  logic             xlink_evt,
  input  logic             xlink_lvl,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             pin_in,
  input  logic             flag_clr,
  output logic             pin_oe,
  output logic             pin_out,
  output logic [CNT_W-1:0] cap_val,
  output logic             chan_flag,
  output logic             pin_rd
);
  logic cap_src, src_sync, pin_sync;
  logic cap_arm, cap_evt, cmp_hit, oc_drive, oc_q;

  // capture sees whatever is on the pad: the port data when driven out
  assign cap_src = dir_bit ? port_data : pin_in;

  tpc_sync #(.STAGES(SYNC_STAGES)) u_src_sync (
    .clk(clk), .rst(rst), .d(cap_src), .q(src_sync)
  );

  tpc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  assign cap_arm  = tmr_en & ~cmp_sel;
  assign cmp_hit  = tmr_en & cmp_sel & (cnt_val == cmp_val);
  assign oc_drive = tmr_en & cmp_sel & (act_sel != ACT_NONE);

  tpc_edge_cap #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .arm(cap_arm),
    .edge_sel(edge_sel_e'(edge_sel)), .lvl(src_sync),
    .cnt(cnt_val), .cap_evt(cap_evt), .cap_q(cap_val)
  );

  tpc_oc_latch u_oc (
    .clk(clk), .rst(rst), .en(tmr_en), .drive(oc_drive),
    .mode(oc_act_e'(act_sel)), .hit(cmp_hit),
    .xmask(xlink_mask), .xevt(xlink_evt), .xlvl(xlink_lvl), .oc_q(oc_q)
  );

  tpc_flag u_flag (
    .clk(clk), .rst(rst), .set(cap_evt | cmp_hit), .clr(flag_clr),
    .flag(chan_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= 1'b0;
      pin_out <= 1'b0;
      pin_rd  <= 1'b0;
    end else begin
      pin_oe  <= oc_drive | dir_bit;
      pin_out <= oc_drive ? oc_q : port_data;
      pin_rd  <= dir_bit ? port_data : pin_sync;
    end
  end

  // R8
  oc_override_chk: assert property (@(posedge clk) disable iff (rst)
    (tmr_en && cmp_sel && act_sel != 2'b00) |=> pin_oe);

  // R2
  gpio_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !tmr_en |=> (pin_oe == $past(dir_bit)) && (pin_out == $past(port_data)));

  // R6
  cap_chan_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_sel |=> (pin_oe == $past(dir_bit)));

  // R10
  read_drv_chk: assert property (@(posedge clk) disable iff (rst)
    dir_bit |=> (pin_rd == $past(port_data)));

  // R2
  no_flag_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!tmr_en && !chan_flag) |=> !chan_flag);
endmodule

// File: tb/tmr_pin_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_pin_ctrl_bench;
  localparam int CW   = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmr_en = 0, dir_bit = 0, port_data = 0, cmp_sel = 0;
  logic [1:0] edge_sel = 0, act_sel = 0;
  logic xlink_mask = 0, xlink_evt = 0, xlink_lvl = 0;
  logic [CW-1:0] cnt_val = 0, cmp_val = 16'hFFFF;
  logic pin_in = 0, flag_clr = 0;
  logic pin_oe, pin_out, chan_flag, pin_rd;
  logic [CW-1:0] cap_val;

  int total = 0, fails = 0;
  string cur_req = "R1";
  bit started = 0;

  always #2.5 clk = ~clk;

  tmr_pin_ctrl #(.CNT_W(CW), .SYNC_STAGES(SYNC)) u_tmr_pin_ctrl (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .dir_bit(dir_bit),
    .port_data(port_data), .cmp_sel(cmp_sel), .edge_sel(edge_sel),
    .act_sel(act_sel), .xlink_mask(xlink_mask), .xlink_evt(xlink_evt),
    .xlink_lvl(xlink_lvl), .cnt_val(cnt_val), .cmp_val(cmp_val),
    .pin_in(pin_in), .flag_clr(flag_clr), .pin_oe(pin_oe),
    .pin_out(pin_out), .cap_val(cap_val), .chan_flag(chan_flag),
    .pin_rd(pin_rd)
  );

  // reference model state
  int sh[SYNC+2];
  int pq[SYNC+2];
  logic m_oe = 0, m_out = 0, m_rd = 0, m_flag = 0, m_oc = 0;
  logic [CW-1:0] m_cap = 0;

  always @(posedge clk) begin
    bit rise, fall, drv, capev, hit;
    started = 1;
    if (rst) begin
      for (int i = 0; i < SYNC + 2; i++) begin sh[i] = 0; pq[i] = 0; end
      m_oe = 0; m_out = 0; m_rd = 0; m_flag = 0; m_oc = 0; m_cap = 0;
    end else begin
      for (int i = SYNC + 1; i > 0; i--) begin sh[i] = sh[i-1]; pq[i] = pq[i-1]; end
      sh[0] = dir_bit ? int'(port_data) : int'(pin_in);
      pq[0] = int'(pin_in);
      rise  = (sh[SYNC] == 1) && (sh[SYNC+1] == 0);
      fall  = (sh[SYNC] == 0) && (sh[SYNC+1] == 1);
      drv   = tmr_en && cmp_sel && act_sel != 0;
      m_oe  = drv || dir_bit;
      m_out = drv ? m_oc : port_data;
      m_rd  = dir_bit ? port_data : logic'(pq[SYNC]);
      capev = tmr_en && !cmp_sel &&
              ((edge_sel == 1 && rise) || (edge_sel == 2 && fall) ||
               (edge_sel == 3 && (rise || fall)));
      hit   = tmr_en && cmp_sel && (cnt_val == cmp_val);
      if (capev) m_cap = cnt_val;
      if (capev || hit) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (!tmr_en) m_oc = 0;
      else if (drv && xlink_mask && xlink_evt) m_oc = xlink_lvl;
      else if (hit) begin
        case (act_sel)
          2'd1: m_oc = !m_oc;
          2'd2: m_oc = 0;
          2'd3: m_oc = 1;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk(cur_req, "pin_oe", 32'(pin_oe), 32'(m_oe));
      chk(cur_req, "pin_out", 32'(pin_out), 32'(m_out));
      chk(cur_req, "pin_rd", 32'(pin_rd), 32'(m_rd));
      chk(cur_req, "chan_flag", 32'(chan_flag), 32'(m_flag));
      chk(cur_req, "cap_val", 32'(cap_val), 32'(m_cap));
    end
  end

  always @(negedge clk) cnt_val <= cnt_val + 1'b1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1; step(1); flag_clr = 0; step(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [CW-1:0] old_cap;
    // R1 reset state
    step(3);
    chk("R1", "oe", 32'(pin_oe), 0);
    chk("R1", "flag", 32'(chan_flag), 0);
    chk("R1", "cap", 32'(cap_val), 0);
    rst = 0;

    // R2 timer disabled, plain GPIO
    cur_req = "R2";
    dir_bit = 1; port_data = 1; step(2);
    chk("R2", "oe", 32'(pin_oe), 1);
    chk("R2", "out", 32'(pin_out), 1);
    port_data = 0; step(2);
    chk("R2", "out", 32'(pin_out), 0);
    dir_bit = 0; pin_in = 1; step(4); pin_in = 0; step(4);
    chk("R2", "flag", 32'(chan_flag), 0);

    // R3 capture channel, edges disabled
    cur_req = "R3";
    tmr_en = 1; cmp_sel = 0; edge_sel = 0;
    for (int i = 0; i < 6; i++) begin pin_in = ~pin_in; step(3); end
    pin_in = 0; step(4);
    chk("R3", "flag", 32'(chan_flag), 0);
    chk("R3", "cap", 32'(cap_val), 0);

    // R4 rising edge
    cur_req = "R4";
    edge_sel = 2'b01; step(4);
    pin_in = 1; step(5);
    chk("R4", "flag rise", 32'(chan_flag), 1);
    chk("R4", "cap nonzero", 32'(cap_val != 0), 1);
    clear_flag();
    old_cap = cap_val;
    pin_in = 0; step(5);
    chk("R4", "no cap on fall", 32'(cap_val), 32'(old_cap));
    // falling edge
    edge_sel = 2'b10; step(2);
    pin_in = 1; step(5); pin_in = 0; step(5);
    chk("R4", "flag fall", 32'(chan_flag), 1);
    clear_flag();
    // either edge
    edge_sel = 2'b11;
    pin_in = 1; step(5);
    chk("R4", "flag any rise", 32'(chan_flag), 1);
    clear_flag();
    pin_in = 0; step(5);
    chk("R4", "flag any fall", 32'(chan_flag), 1);
    clear_flag();

    // R5 capture of CPU-driven data
    cur_req = "R5";
    edge_sel = 2'b01; dir_bit = 1; port_data = 0; step(5);
    clear_flag();
    pin_in = 1; step(5);
    chk("R5", "ext ignored when driven", 32'(chan_flag), 0);
    port_data = 1; step(5);
    chk("R5", "flag from data", 32'(chan_flag), 1);
    clear_flag();
    port_data = 0; dir_bit = 0; pin_in = 0; step(5);
    clear_flag();

    // R6 link has no effect on capture channel
    cur_req = "R6";
    xlink_mask = 1; xlink_lvl = 1;
    for (int i = 0; i < 6; i++) begin xlink_evt = ~xlink_evt; step(2); end
    xlink_evt = 0;
    chk("R6", "oe", 32'(pin_oe), 0);
    chk("R6", "flag", 32'(chan_flag), 0);
    xlink_mask = 0; xlink_lvl = 0;

    // R7 compare, no pin action
    cur_req = "R7";
    cmp_sel = 1; act_sel = 0; dir_bit = 0;
    cmp_val = cnt_val + 16'd6; step(10);
    chk("R7", "flag", 32'(chan_flag), 1);
    chk("R7", "oe", 32'(pin_oe), 0);
    clear_flag();

    // R8 / R9 / R10 compare actions
    cur_req = "R8";
    act_sel = 2'b11; pin_in = 1; step(2);
    chk("R8", "oe forced", 32'(pin_oe), 1);
    step(2);
    chk("R10", "rd external", 32'(pin_rd), 1);
    cur_req = "R9";
    cmp_val = cnt_val + 16'd5; step(9);
    chk("R9", "set", 32'(pin_out), 1);
    act_sel = 2'b10; cmp_val = cnt_val + 16'd5; step(9);
    chk("R9", "clear", 32'(pin_out), 0);
    act_sel = 2'b01; cmp_val = cnt_val + 16'd5; step(9);
    chk("R9", "toggle", 32'(pin_out), 1);
    cur_req = "R10";
    dir_bit = 1; port_data = 0; step(2);
    chk("R10", "rd data", 32'(pin_rd), 0);
    chk("R8", "still oe", 32'(pin_oe), 1);
    dir_bit = 0; pin_in = 0; step(4);
    chk("R10", "rd ext low", 32'(pin_rd), 0);

    // R11 set beats clear
    cur_req = "R11";
    clear_flag();
    cmp_val = cnt_val + 16'd4; flag_clr = 1;
    for (int i = 0; i < 8; i++) begin
      step(1);
    end
    flag_clr = 0; step(1);
    chk("R11", "cleared after", 32'(chan_flag), 0);

    // R13 cross-channel link
    cur_req = "R13";
    act_sel = 2'b11; xlink_mask = 1; xlink_lvl = 0; xlink_evt = 1;
    cmp_val = cnt_val + 16'd1; step(3);
    xlink_evt = 0; step(2);
    chk("R13", "link wins", 32'(pin_out), 0);
    xlink_lvl = 1; xlink_evt = 1; step(1); xlink_evt = 0; step(2);
    chk("R13", "link high", 32'(pin_out), 1);
    xlink_mask = 0; clear_flag();

    // R12 disable clears latch
    cur_req = "R12";
    tmr_en = 0; step(3);
    chk("R12", "gpio out", 32'(pin_out), 32'(port_data));
    tmr_en = 1; act_sel = 2'b01; step(2);
    chk("R12", "restart low", 32'(pin_out), 0);
    step(3);

    finish_run();
  end
endmodule